// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A binary counter, eight bits wide by default, whose every change of state happens on the rising clock edge. On each edge it either loads a parallel data word, holds its value, steps up by one or steps down by one. Which of these it does depends on an active-low load strobe, a direction input and two active-low count enables. Both enables must be low for a step to happen.

One enable is the broadside enable. It is shared by every stage of a chain. The other is the chain enable, which also qualifies the active-low terminal-count output. That output goes low while the count sits at its last value in the selected direction: all ones when counting up, all zeros when counting down. Wiring each stage's terminal count to the next stage's chain enable builds a wider counter with lookahead. An active-low synchronous reset clears the register to zero and is meant only for initialisation.

Top module: `updn_counter`

## Requirements
- R1: While rst_ni is low at a rising edge, count_o becomes zero at that edge. This takes priority over load_ni and all other controls.
- R2: When load_ni is low at a rising edge (rst_ni high), count_o takes data_i at that edge, whatever cnt_en_ni, chain_en_ni and up_i are.
- R3: With load_ni high and cnt_en_ni high, count_o keeps its value across the edge.
- R4: With load_ni high and chain_en_ni high, count_o keeps its value across the edge, and tc_no is high for as long as chain_en_ni is high.
- R5: With load_ni, cnt_en_ni and chain_en_ni low, count_o = count_o + 1 when up_i is high (1 = up). The count wraps from all ones to zero.
- R6: With load_ni, cnt_en_ni and chain_en_ni low, count_o = count_o - 1 when up_i is low (0 = down). The count wraps from zero to all ones.
- R7: tc_no is low exactly when chain_en_ni is low and either up_i is high with count_o all ones, or up_i is low with count_o zero. load_ni and cnt_en_ni do not affect tc_no.
- R8: tc_no follows changes on up_i and chain_en_ni within the same cycle, with no clock edge in between.
- R9: Several stages form a single wider counter when each stage's tc_no drives the next stage's chain_en_ni and the stages share clk_i, cnt_en_ni and up_i. Loads and steps, including carries and borrows across stage boundaries, then follow the wide value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Synchronous reset to zero, active low |
| load_ni | input | 1 | Parallel load strobe, active low |
| data_i | input | WIDTH | Value loaded when load_ni is low |
| cnt_en_ni | input | 1 | Broadside count enable, active low |
| chain_en_ni | input | 1 | Chain count enable, active low; also qualifies tc_no |
| up_i | input | 1 | Direction: 1 up, 0 down |
| count_o | output | WIDTH | Current count |
| tc_no | output | 1 | Terminal count, active low, combinational |

## Verification
The properties assume that the controls are settled at each rising edge and carry known values whenever rst_ni is high. They also assume that reset is applied for at least one edge before any check that looks back in time. The bench meets these assumptions by changing inputs only one time unit after a rising edge. It holds reset across the first edges and never leaves a control undriven. The combinational terminal-count checks are made between edges, after a direction or enable change, so that no edge can hide the response.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_LOAD = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_decode.sv
module updn_decode
  import updn_pkg::*;
(
  input  logic    load_ni,
  input  logic    cnt_en_ni,
  input  logic    chain_en_ni,
  input  logic    up_i,
  output cnt_op_e op_o
);
  always_comb begin
    if (!load_ni)                      op_o = OP_LOAD;
    else if (cnt_en_ni || chain_en_ni) op_o = OP_HOLD;
    else if (up_i)                     op_o = OP_UP;
    else                               op_o = OP_DOWN;
  end
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_next_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_LOAD: q_next_o = d_i;
      OP_UP:   q_next_o = q_i + ONE;
      OP_DOWN: q_next_o = q_i - ONE;
      default: q_next_o = q_i;
    endcase
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             chain_en_ni,
  output logic             tc_no
);
  logic [WIDTH-1:0] at_end;

  // each bit sits at its end value for the current direction
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign at_end[i] = up_i ? q_i[i] : ~q_i[i];
  end

  assign tc_no = ~(~chain_en_ni & (&at_end));
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cnt_en_ni,
  input  logic             chain_en_ni,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_no
);
  cnt_op_e          op;
  logic [WIDTH-1:0] q_q, q_next;

  updn_decode u_decode (
    .load_ni    (load_ni),
    .cnt_en_ni  (cnt_en_ni),
    .chain_en_ni(chain_en_ni),
    .up_i       (up_i),
    .op_o       (op)
  );

  updn_next #(.WIDTH(WIDTH)) u_next (
    .op_i    (op),
    .q_i     (q_q),
    .d_i     (data_i),
    .q_next_o(q_next)
  );

  updn_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i        (q_q),
    .up_i       (up_i),
    .chain_en_ni(chain_en_ni),
    .tc_no      (tc_no)
  );

  // reset is synchronous: no path into the register bypasses the clock
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_next;
  end

  assign count_o = q_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             cnt_en_ni,
  input logic             chain_en_ni,
  input logic             up_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_no
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> count_o == '0);

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R3
  hold_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_ni) |=> $stable(count_o));

  // R4
  hold_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && chain_en_ni) |=> $stable(count_o));

  // R4
  chain_tc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_en_ni |-> tc_no);

  // R5
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && !chain_en_ni && up_i)
      |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R6
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && !chain_en_ni && !up_i)
      |=> count_o == WIDTH'($past(count_o) - 1'b1));

  // R7
  tc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_no && load_ni && !cnt_en_ni)
      |=> count_o == ($past(up_i) ? '0 : ALL_ONES));
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .cnt_en_ni  (cnt_en_ni),
  .chain_en_ni(chain_en_ni),
  .up_i       (up_i),
  .count_o    (count_o),
  .tc_no      (tc_no)
);

// File: tb/updn_counter_tb.sv
module updn_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int STAGES = 3;
  localparam int CW = W * STAGES;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_ni = 1'b1, cnt_en_ni = 1'b1, chain_en_ni = 1'b1, up_i = 1'b1;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] count_o;
  logic tc_no;

  logic c_load_ni = 1'b1, c_cnt_en_ni = 1'b1, c_up_i = 1'b1;
  logic [CW-1:0] c_data = '0;
  logic [CW-1:0] c_count;
  logic [STAGES:0] c_chain;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  updn_counter #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .data_i(data_i),
    .cnt_en_ni(cnt_en_ni), .chain_en_ni(chain_en_ni), .up_i(up_i),
    .count_o(count_o), .tc_no(tc_no)
  );

  assign c_chain[0] = 1'b0;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    updn_counter #(.WIDTH(W)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(c_load_ni),
      .data_i(c_data[s*W +: W]), .cnt_en_ni(c_cnt_en_ni),
      .chain_en_ni(c_chain[s]), .up_i(c_up_i),
      .count_o(c_count[s*W +: W]), .tc_no(c_chain[s+1])
    );
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; load_ni = 1'b0; data_i = 8'h5A; up_i = 1'b0; chain_en_ni = 1'b0;
    cnt_en_ni = 1'b0;
    tick(); tick();
    check("R1 reset clears over load", count_o, 0);
    check("R7 tc at zero counting down", tc_no, 0);
    rst_ni = 1'b1; load_ni = 1'b1; cnt_en_ni = 1'b1;
  endtask

  task automatic t_load();
    load_ni = 1'b0; data_i = 8'hA5; cnt_en_ni = 1'b0; chain_en_ni = 1'b0; up_i = 1'b1;
    tick();
    check("R2 load with enables active", count_o, 8'hA5);
    data_i = 8'h3C; cnt_en_ni = 1'b1; chain_en_ni = 1'b1; up_i = 1'b0;
    tick();
    check("R2 load with enables idle", count_o, 8'h3C);
    load_ni = 1'b1;
  endtask

  task automatic t_hold_bcast();
    load_ni = 1'b0; data_i = 8'hFF; tick(); load_ni = 1'b1;
    cnt_en_ni = 1'b1; chain_en_ni = 1'b0; up_i = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check("R3 hold on broadside enable", count_o, 8'hFF);
    check("R7 tc unaffected by broadside enable", tc_no, 0);
  endtask

  task automatic t_hold_chain();
    cnt_en_ni = 1'b0; chain_en_ni = 1'b1; up_i = 1'b1;
    #1;
    check("R4 tc forced high by chain enable", tc_no, 1);
    tick(); tick();
    check("R4 hold on chain enable", count_o, 8'hFF);
    cnt_en_ni = 1'b1;
  endtask

  task automatic t_up();
    load_ni = 1'b0; data_i = 8'hFD; tick(); load_ni = 1'b1;
    cnt_en_ni = 1'b0; chain_en_ni = 1'b0; up_i = 1'b1;
    tick(); check("R5 up step", count_o, 8'hFE);
    tick(); check("R5 up step to top", count_o, 8'hFF);
    tick(); check("R5 up wrap", count_o, 8'h00);
    tick(); check("R5 up after wrap", count_o, 8'h01);
    cnt_en_ni = 1'b1;
  endtask

  task automatic t_down();
    load_ni = 1'b0; data_i = 8'h02; tick(); load_ni = 1'b1;
    cnt_en_ni = 1'b0; chain_en_ni = 1'b0; up_i = 1'b0;
    tick(); check("R6 down step", count_o, 8'h01);
    tick(); check("R6 down to zero", count_o, 8'h00);
    tick(); check("R6 down wrap", count_o, 8'hFF);
    tick(); check("R6 down after wrap", count_o, 8'hFE);
    cnt_en_ni = 1'b1;
  endtask

  task automatic t_tc();
    load_ni = 1'b0; data_i = 8'hFF; tick(); load_ni = 1'b1;
    cnt_en_ni = 1'b1; chain_en_ni = 1'b0; up_i = 1'b1; #1;
    check("R7 tc at ones counting up", tc_no, 0);
    up_i = 1'b0; #1;
    check("R8 tc follows direction without edge", tc_no, 1);
    up_i = 1'b1; #1;
    check("R8 tc returns with direction", tc_no, 0);
    chain_en_ni = 1'b1; #1;
    check("R8 tc follows chain enable without edge", tc_no, 1);
    chain_en_ni = 1'b0; load_ni = 1'b0; data_i = 8'h00; #1;
    check("R7 tc unaffected by load strobe", tc_no, 0);
    tick(); load_ni = 1'b1; up_i = 1'b0; #1;
    check("R7 tc at zero counting down", tc_no, 0);
    load_ni = 1'b0; data_i = 8'h7F; tick(); load_ni = 1'b1; up_i = 1'b1; #1;
    check("R7 tc inactive mid range", tc_no, 1);
  endtask

  task automatic t_cascade();
    c_load_ni = 1'b0; c_data = 24'h00FFFE; tick(); c_load_ni = 1'b1;
    check("R9 chain load", c_count, 24'h00FFFE);
    c_cnt_en_ni = 1'b0; c_up_i = 1'b1;
    tick(); check("R9 chain up", c_count, 24'h00FFFF);
    tick(); check("R9 chain carry across two stages", c_count, 24'h010000);
    tick(); check("R9 chain up after carry", c_count, 24'h010001);
    c_up_i = 1'b0;
    tick(); check("R9 chain down", c_count, 24'h010000);
    tick(); check("R9 chain borrow across two stages", c_count, 24'h00FFFF);
    c_cnt_en_ni = 1'b1;
    tick(); check("R9 chain hold", c_count, 24'h00FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_load();
    t_hold_bcast();
    t_hold_chain();
    t_up();
    t_down();
    t_tc();
    t_cascade();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule